// File: doc/BRIEF.md
# Three-Kernel 3x3 Convolution Stage

This block runs a same-size 2D convolution over a 28x28 single-channel image with three fixed 3x3 kernels. It yields three 28x28 feature maps, 2352 values in all. The image is first written into an internal frame store through a load port. A start pulse then launches one raster scan over every output position.

Nine tap units, one for each window position, multiply the current 3x3 window in parallel. The three kernels share these multipliers in turn. Each output position takes three consecutive cycles, with kernel 0 first, then kernel 1, then kernel 2. Each 9-term sum is combined with a per-kernel bias, shifted right to normalise it, clamped to 9 bits and passed through a rectifier. The result leaves the block with a map index and a pixel index.

All data is 9-bit two's complement with 7 fraction bits. Weights and biases are constants computed inside the block.

Top module: `conv3_stage`

## Requirements
- R1: After reset, `out_valid` stays low until a start pulse is given.
- R2: Window taps that fall outside the image contribute zero. Tap t = 3*(dy+1) + (dx+1) takes the pixel at row y+dy and column x+dx, where dy and dx each range over -1..1.
- R3: Each tap product is pixel times weight, arithmetically shifted right by 7 (floor), then clamped to [-256, 255].
- R4: The nine products plus the kernel bias are summed, arithmetically shifted right by 1 (floor), then clamped to [-256, 255].
- R5: Negative results are output as 0, and non-negative results pass unchanged.
- R6: Each frame emits exactly 2352 outputs. Pixel index y*28+x runs in raster order 0..783, and each pixel's three outputs appear on consecutive cycles with map index 0, 1, 2.
- R7: Kernel 0 weights are 8*(t+1) with bias -16. Kernel 1 weights are 64 at t=4 and -8 at every other tap, with bias 4. Kernel 2 weights are 16*(t mod 3) - 16 with bias 8.
- R8: Load writes that arrive while a scan is running are ignored. The stored image is unchanged for that scan and for later scans.
- R9: A start pulse during a running scan is ignored. The running frame still emits exactly 2352 outputs and nothing follows it.
- R10: Within an image row, outputs are back to back: the map-0 output of column x>0 comes on the cycle right after the map-2 output of column x-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Write one image pixel into the frame store |
| load_addr | input | 10 | Pixel address y*28+x |
| load_pixel | input | 9 | Signed pixel value |
| start | input | 1 | Begin a frame scan (single-cycle pulse) |
| out_valid | output | 1 | Output value is valid |
| out_map | output | 2 | Feature map (kernel) index |
| out_pix | output | 10 | Raster pixel index y*28+x |
| out_value | output | 9 | Rectified, clamped result |

## Verification
A write on the load port can land in the same cycle as the scan reads the frame store for the current window. The write must then lose. The bench provokes this by writing zeros to every address in the middle of a scan. It then judges the result by comparing that frame and a second full scan against the model of the original image. A second start pulse that coincides with an active scan is provoked the same way, and it is judged by the exact output count and by the raster order.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

  localparam int NUM_MAPS = 3;
  localparam int NUM_TAPS = 9;
  localparam int MAP_W    = 2;

  // Kernel coefficient for map k, tap t (t = 3*row_offset + col_offset, 0..8)
  function automatic int tap_weight(input int k, input int t);
    case (k)
      0:       return 8 * (t + 1);
      1:       return (t == 4) ? 64 : -8;
      default: return (t % 3) * 16 - 16;
    endcase
  endfunction

  function automatic int map_bias(input int k);
    case (k)
      0:       return -16;
      1:       return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/conv3_frame_mem.sv
module conv3_frame_mem #(
  parameter int DEPTH  = 784,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/conv3_scan_ctrl.sv
module conv3_scan_ctrl import conv3_pkg::*; #(
  parameter int IMG_W  = 28,
  parameter int IMG_H  = 28,
  parameter int DATA_W = 9,
  parameter int PIX_AW = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     ld_valid,
  input  logic [PIX_AW-1:0]        ld_addr,
  output logic                     wr_en,
  output logic                     rd_en,
  output logic [PIX_AW-1:0]        rd_addr,
  input  logic signed [DATA_W-1:0] rd_data,
  output logic signed [DATA_W-1:0] win [NUM_TAPS],
  output logic                     c_valid,
  output logic [MAP_W-1:0]         c_map,
  output logic [PIX_AW-1:0]        c_pix
);

  localparam int NUM_PIX = IMG_W * IMG_H;
  localparam int ROW_W   = $clog2(IMG_H);
  localparam int STEP_W  = $clog2(IMG_W + 1);

  logic              busy;
  logic [ROW_W-1:0]  row;
  logic [STEP_W-1:0] step;
  logic [1:0]        ph;
  int                fetch_row;
  logic              fetch_in;

  // fetch: phase 0/1/2 reads rows y-1/y/y+1 at column "step"
  always_comb begin
    fetch_row = int'(row) + int'(ph) - 1;
    fetch_in  = (fetch_row >= 0) && (fetch_row < IMG_H) && (int'(step) < IMG_W);
    rd_en     = busy && fetch_in;
    rd_addr   = fetch_in ? PIX_AW'(fetch_row * IMG_W + int'(step)) : '0;
    wr_en     = ld_valid && !busy && (int'(ld_addr) < NUM_PIX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      row  <= '0;
      step <= '0;
      ph   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        row  <= '0;
        step <= '0;
        ph   <= '0;
      end
    end else if (ph == 2'd2) begin
      ph <= '0;
      if (int'(step) == IMG_W) begin
        step <= '0;
        if (int'(row) == IMG_H - 1) busy <= 1'b0;
        else                         row  <= row + 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // stage aligned with the registered memory read
  logic              f_valid, f_zero, f_first;
  logic [1:0]        f_ph;
  logic [PIX_AW-1:0] f_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_valid <= 1'b0;
      f_zero  <= 1'b1;
      f_first <= 1'b0;
      f_ph    <= '0;
      f_pos   <= '0;
    end else begin
      f_valid <= busy;
      f_zero  <= !fetch_in;
      f_first <= (step == '0);
      f_ph    <= ph;
      f_pos   <= PIX_AW'(int'(row) * IMG_W + int'(step) - 1);
    end
  end

  logic signed [DATA_W-1:0] pix_in, col_top, col_mid;
  logic                     shift;

  assign pix_in = f_zero ? '0 : rd_data;
  assign shift  = f_valid && (f_ph == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_top <= '0;
      col_mid <= '0;
      for (int t = 0; t < NUM_TAPS; t++) win[t] <= '0;
      c_valid <= 1'b0;
      c_map   <= '0;
      c_pix   <= '0;
    end else begin
      if (f_valid && f_ph == 2'd0) col_top <= pix_in;
      if (f_valid && f_ph == 2'd1) col_mid <= pix_in;
      if (shift) begin
        for (int r = 0; r < 3; r++) begin
          win[r*3]   <= f_first ? '0 : win[r*3+1];
          win[r*3+1] <= f_first ? '0 : win[r*3+2];
        end
        win[2] <= col_top;
        win[5] <= col_mid;
        win[8] <= pix_in;
      end
      if (shift && !f_first) begin
        c_valid <= 1'b1;
        c_map   <= '0;
        c_pix   <= f_pos;
      end else if (c_valid) begin
        if (c_map == MAP_W'(NUM_MAPS - 1)) c_valid <= 1'b0;
        else                                c_map   <= c_map + 1'b1;
      end
    end
  end

  // R10
  kernel_rotation_chk: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_map != '0) |-> ($past(c_valid) && $past(c_map) == c_map - 1'b1));

  // R9
  row_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (row >= $past(row)));

endmodule

// File: rtl/conv3_tap_pe.sv
module conv3_tap_pe import conv3_pkg::*; #(
  parameter int DATA_W    = 9,
  parameter int FRAC_BITS = 7,
  parameter int TAP       = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MAP_W-1:0]         map_sel,
  input  logic signed [DATA_W-1:0] pix,
  output logic signed [DATA_W-1:0] prod
);

  localparam int PW = 2 * DATA_W;
  localparam logic signed [PW-1:0] P_HI = PW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] P_LO = PW'(-(1 << (DATA_W - 1)));

  logic signed [DATA_W-1:0] w;
  logic signed [PW-1:0]     full, shifted;
  logic signed [DATA_W-1:0] prod_n;

  always_comb begin
    w       = DATA_W'(tap_weight(int'(map_sel), TAP));
    full    = pix * w;
    shifted = full >>> FRAC_BITS;
    if (shifted > P_HI)      prod_n = P_HI[DATA_W-1:0];
    else if (shifted < P_LO) prod_n = P_LO[DATA_W-1:0];
    else                     prod_n = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= prod_n;
  end

  // R3
  zero_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pix) == '0) |-> (prod == '0));

endmodule

// File: rtl/conv3_out_stage.sv
module conv3_out_stage import conv3_pkg::*; #(
  parameter int DATA_W     = 9,
  parameter int NORM_SHIFT = 1,
  parameter int PIX_AW     = 10,
  parameter int NUM_PIX    = 784
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [MAP_W-1:0]         in_map,
  input  logic [PIX_AW-1:0]        in_pix,
  input  logic signed [DATA_W-1:0] prods [NUM_TAPS],
  output logic                     out_valid,
  output logic [MAP_W-1:0]         out_map,
  output logic [PIX_AW-1:0]        out_pix,
  output logic [DATA_W-1:0]        out_value
);

  localparam int SUM_W = DATA_W + 4;
  localparam logic signed [SUM_W-1:0] S_HI = SUM_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] S_LO = SUM_W'(-(1 << (DATA_W - 1)));

  logic signed [SUM_W-1:0]  acc, scaled;
  logic signed [DATA_W-1:0] clamped;
  logic [DATA_W-1:0]        rect;

  always_comb begin
    acc = SUM_W'(map_bias(int'(in_map)));
    for (int i = 0; i < NUM_TAPS; i++) acc = acc + SUM_W'(prods[i]);
    scaled = acc >>> NORM_SHIFT;
    if (scaled > S_HI)      clamped = S_HI[DATA_W-1:0];
    else if (scaled < S_LO) clamped = S_LO[DATA_W-1:0];
    else                    clamped = scaled[DATA_W-1:0];
    rect = clamped[DATA_W-1] ? '0 : clamped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_map   <= '0;
      out_pix   <= '0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      out_map   <= in_map;
      out_pix   <= in_pix;
      out_value <= rect;
    end
  end

  // R5
  relu_sign_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_value[DATA_W-1]);

  // R6
  map_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_map != '0) |->
      ($past(out_valid) && $past(out_map) == out_map - 1'b1 && out_pix == $past(out_pix)));

  // R6
  pix_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_pix) < NUM_PIX && int'(out_map) < NUM_MAPS));

endmodule

// File: rtl/conv3_stage.sv
module conv3_stage import conv3_pkg::*; #(
  parameter int IMG_W      = 28,
  parameter int IMG_H      = 28,
  parameter int DATA_W     = 9,
  parameter int FRAC_BITS  = 7,
  parameter int NORM_SHIFT = 1,
  localparam int NUM_PIX   = IMG_W * IMG_H,
  localparam int PIX_AW    = $clog2(NUM_PIX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic [PIX_AW-1:0] load_addr,
  input  logic [DATA_W-1:0] load_pixel,
  input  logic              start,
  output logic              out_valid,
  output logic [MAP_W-1:0]  out_map,
  output logic [PIX_AW-1:0] out_pix,
  output logic [DATA_W-1:0] out_value
);

  logic                     wr_en, rd_en;
  logic [PIX_AW-1:0]        rd_addr;
  logic [DATA_W-1:0]        rd_data;
  logic signed [DATA_W-1:0] win   [NUM_TAPS];
  logic signed [DATA_W-1:0] prods [NUM_TAPS];
  logic                     c_valid, t_valid;
  logic [MAP_W-1:0]         c_map, t_map;
  logic [PIX_AW-1:0]        c_pix, t_pix;

  conv3_frame_mem #(.DEPTH(NUM_PIX), .ADDR_W(PIX_AW), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(load_addr), .wdata(load_pixel),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  conv3_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DATA_W(DATA_W), .PIX_AW(PIX_AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ld_valid(load_valid), .ld_addr(load_addr),
    .wr_en(wr_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data($signed(rd_data)),
    .win(win), .c_valid(c_valid), .c_map(c_map), .c_pix(c_pix)
  );

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    conv3_tap_pe #(.DATA_W(DATA_W), .FRAC_BITS(FRAC_BITS), .TAP(t)) u_pe (
      .clk(clk), .rst(rst), .map_sel(c_map), .pix(win[t]), .prod(prods[t])
    );
  end

  // tags follow the product register
  always_ff @(posedge clk) begin
    if (rst) begin
      t_valid <= 1'b0;
      t_map   <= '0;
      t_pix   <= '0;
    end else begin
      t_valid <= c_valid;
      t_map   <= c_map;
      t_pix   <= c_pix;
    end
  end

  conv3_out_stage #(.DATA_W(DATA_W), .NORM_SHIFT(NORM_SHIFT), .PIX_AW(PIX_AW),
                    .NUM_PIX(NUM_PIX)) u_out (
    .clk(clk), .rst(rst), .in_valid(t_valid), .in_map(t_map), .in_pix(t_pix),
    .prods(prods), .out_valid(out_valid), .out_map(out_map), .out_pix(out_pix),
    .out_value(out_value)
  );

endmodule

// File: tb/conv3_stage_tb.sv
`timescale 1ns/1ps
module conv3_stage_tb;

  localparam int W = 28, H = 28, NPIX = W * H, NOUT = 3 * NPIX;

  logic       clk = 1'b0, rst = 1'b1;
  logic       load_valid = 1'b0, start = 1'b0;
  logic [9:0] load_addr = '0;
  logic [8:0] load_pixel = '0;
  logic       out_valid;
  logic [1:0] out_map;
  logic [9:0] out_pix;
  logic [8:0] out_value;

  conv3_stage u_dut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_addr(load_addr),
    .load_pixel(load_pixel), .start(start), .out_valid(out_valid),
    .out_map(out_map), .out_pix(out_pix), .out_value(out_value)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int img_ref [NPIX];
  int cap [NOUT];
  int seq_idx = 0, ord_err = 0, gap_err = 0;
  logic prev_v = 1'b0;
  int   prev_map = 0;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      report();
    end
  end

  always @(negedge clk) begin
    if (out_valid) begin
      if (seq_idx >= NOUT || int'(out_map) != seq_idx % 3 || int'(out_pix) != seq_idx / 3)
        ord_err++;
      if (out_map != 0 && !(prev_v && prev_map == int'(out_map) - 1)) gap_err++;
      if (out_map == 0 && int'(out_pix) % W != 0 && !(prev_v && prev_map == 2)) gap_err++;
      if (out_map < 3 && out_pix < NPIX) cap[int'(out_map) * NPIX + int'(out_pix)] = int'(out_value);
      seq_idx++;
    end
    prev_v   = out_valid;
    prev_map = int'(out_map);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent coefficient tables (R7)
  function automatic int ref_w(input int k, input int t);
    if (k == 0) return 8 * (t + 1);
    if (k == 1) return (t == 4) ? 64 : -8;
    return 16 * (t % 3) - 16;
  endfunction

  function automatic int ref_b(input int k);
    if (k == 0) return -16;
    if (k == 1) return 4;
    return 8;
  endfunction

  function automatic int clamp9(input int v);
    if (v > 255) return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  function automatic int model(input int k, input int pix);
    int x = pix % W, y = pix / W, acc;
    acc = ref_b(k);
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if (y + dy >= 0 && y + dy < H && x + dx >= 0 && x + dx < W)
          acc += clamp9((img_ref[(y + dy) * W + x + dx] * ref_w(k, 3 * (dy + 1) + dx + 1)) >>> 7);
    acc = clamp9(acc >>> 1);
    return (acc < 0) ? 0 : acc;
  endfunction

  task automatic load_image();
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      load_valid = 1'b1; load_addr = 10'(i); load_pixel = 9'(img_ref[i]);
    end
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic start_frame();
    @(negedge clk);
    seq_idx = 0; ord_err = 0; gap_err = 0;
    for (int i = 0; i < NOUT; i++) cap[i] = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_frame();
    for (int i = 0; i < 3000 && seq_idx < NOUT; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic compare_frame(input string req);
    int bad = 0, first_i = -1;
    chk(seq_idx == NOUT, "R6", "output count", seq_idx, NOUT);
    chk(ord_err == 0, "R6", "raster/map order errors", ord_err, 0);
    chk(gap_err == 0, "R10", "back-to-back gaps", gap_err, 0);
    for (int i = 0; i < NOUT; i++) begin
      chk(cap[i] == model(i / NPIX, i % NPIX), req, $sformatf("map %0d pix %0d", i / NPIX, i % NPIX),
          cap[i], model(i / NPIX, i % NPIX));
      if (cap[i] != model(i / NPIX, i % NPIX)) begin bad++; if (first_i < 0) first_i = i; end
    end
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R1", "valid outputs after reset", seen, 0);
  endtask

  task automatic t_all_max();
    for (int i = 0; i < NPIX; i++) img_ref[i] = 255;
    load_image();
    start_frame();
    wait_frame();
    compare_frame("R4");
    chk(cap[0] == 214, "R2", "corner map0 with padding", cap[0], 214);
    chk(cap[14 * W + 14] == 255, "R4", "interior map0 clamps", cap[14 * W + 14], 255);
    chk(cap[NPIX + 14 * W + 14] == 1, "R7", "interior map1", cap[NPIX + 14 * W + 14], 1);
    chk(cap[2 * NPIX + 14 * W + 14] == 2, "R7", "interior map2", cap[2 * NPIX + 14 * W + 14], 2);
  endtask

  task automatic t_random();
    int s = 12345, zeros = 0, pos = 0;
    for (int i = 0; i < NPIX; i++) begin
      s = (s * 1103515 + 12345) & 32'h7fffffff;
      img_ref[i] = ((s >> 8) % 512) - 256;
    end
    load_image();
    start_frame();
    wait_frame();
    compare_frame("R5");
    for (int i = 0; i < NOUT; i++) begin
      if (cap[i] == 0) zeros++;
      if (cap[i] > 0) pos++;
    end
    chk(zeros > 0, "R5", "rectified zero outputs present", zeros, 1);
    chk(pos > 0, "R3", "positive outputs present", pos, 1);
  endtask

  task automatic t_impulse();
    for (int i = 0; i < NPIX; i++) img_ref[i] = 0;
    img_ref[NPIX - 1] = 100;
    img_ref[0] = -100;
    load_image();
    start_frame();
    wait_frame();
    compare_frame("R2");
    chk(cap[NPIX + NPIX - 1] == 27, "R2", "last-corner map1", cap[NPIX + NPIX - 1], 27);
  endtask

  task automatic t_load_during_scan();
    for (int i = 0; i < NPIX; i++) img_ref[i] = (i % W) * 7 + (i / W) * 3 - 100;
    load_image();
    start_frame();
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      load_valid = 1'b1; load_addr = 10'(i); load_pixel = '0;
    end
    @(negedge clk);
    load_valid = 1'b0;
    wait_frame();
    compare_frame("R8");
    start_frame();
    wait_frame();
    compare_frame("R8");
  endtask

  task automatic t_start_busy();
    start_frame();
    repeat (500) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_frame();
    repeat (200) @(negedge clk);
    chk(seq_idx == NOUT, "R9", "outputs after restart attempt", seq_idx, NOUT);
    compare_frame("R9");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_max();
    t_random();
    t_impulse();
    t_load_during_scan();
    t_start_busy();
    report();
  end

endmodule